// File: doc/BRIEF.md
# Enable Round-Trip Crossing

This block moves a single generator-enable bit from the system clock domain into a slow, always-on clock domain. The slow domain keeps running through deep-sleep states. The block then carries the bit that actually arrived back into the system domain, where it becomes a read-only status bit. Software compares the requested enable with this status to see whether an enable or a disable has really taken hold on the slow side.

The request is first registered in the system domain. It then passes through a synchronizer clocked by the slow clock, and the synchronized value drives the slow-domain generator. A second synchronizer clocked by the system clock carries the slow-domain value back as status. A configuration-lock output tells the register block when writes to the slow generator's settings must be refused.

To turn the generator off safely, software follows a fixed sequence. If the request is already 0, nothing needs doing. Otherwise it waits for status to read 1, clears the request, and then waits for status to read 0. While a new enable is still travelling, the request reads 1 and the status still reads 0.

Top module: `lpx_enable_xing`

## Requirements
- R1: `slow_enable` follows `enable_req` after one system-clock launch flop and `STAGES` slow-clock flops. It therefore rises no earlier than `STAGES-1` full slow periods after the request is set.
- R2: `enable_status` is `slow_enable` passed back through `STAGES` system-clock flops. When `enable_status` is first seen at 1, `slow_enable` is already 1.
- R3: After `enable_req` is set, `enable_status` reaches 1 within `STAGES*P/Tsys + STAGES + 4` system cycles. Here P is the slow period and Tsys is the system period. This holds for slow-to-system clock ratios of 1:30 and above.
- R4: After `enable_req` is set, `enable_status` reads 0 for at least `(STAGES-1)*P/Tsys` system cycles, so an enable that is still in flight is visible.
- R5: After `enable_req` is cleared, `enable_status` stays 1 for at least `(STAGES-1)*P/Tsys` system cycles. It then falls within the same bound as R3. When it falls, `slow_enable` is already 0.
- R6: `cfg_lock` is 1 whenever `enable_req` or `enable_status` is 1, and 0 when both are 0.
- R7: An asserted `sys_rst_n` (active low, asynchronous) clears `enable_status` at once. With `enable_req` at 0, it also clears `cfg_lock`. The cleared launch flop then brings `slow_enable` to 0 within `STAGES` slow periods.
- R8: An asserted `slow_rst_n` (active low, asynchronous) forces `slow_enable` to 0 at once, and `enable_status` falls within `STAGES+1` system cycles. After release, with `enable_req` still 1, the round trip completes again within the R3 bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System-domain asynchronous reset, active low |
| slow_clk | input | 1 | Slow always-on clock |
| slow_rst_n | input | 1 | Slow-domain asynchronous reset, active low |
| enable_req | input | 1 | Generator enable from the register block (system domain) |
| slow_enable | output | 1 | Enable as seen by the slow-domain generator |
| enable_status | output | 1 | Round-trip status in the system domain |
| cfg_lock | output | 1 | High while slow-generator settings must not be written |

## Verification
The hardest case to reach from the ports is the window in which the request and the status disagree. The crossing moves at the pace of the slow clock, so this window lasts tens of system cycles. Its length also drifts with the phase between the two clocks. The bench runs the full enable and disable sequence at two slow periods, 30.5 and 47 system cycles. It counts system cycles to the status edge and checks that count against a lower and an upper limit derived from the slow period. It also resets each domain on its own partway through a round trip, to reach the state where one side is cleared while the other still holds the enable.

// File: rtl/lpx_pkg.sv
package lpx_pkg;

  // Default synchronizer depth for each direction of the crossing.
  parameter int unsigned LPX_SYNC_STAGES = 2;

  // Settings of the slow generator are frozen while a request is pending
  // or while the slow domain still reports the generator as running.
  function automatic logic lock_needed(input logic req, input logic status);
    return req | status;
  endfunction

  // Slowest possible round trip, in destination-clock cycles, of a value
  // that crosses forward with ratio fwd_ratio and back with depth stages.
  function automatic int unsigned round_trip_cycles(input int unsigned fwd_ratio,
                                                    input int unsigned stages);
    return stages * fwd_ratio + stages + 4;
  endfunction

endpackage

// File: rtl/lpx_sync.sv
module lpx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lpx_lock.sv
module lpx_lock
  import lpx_pkg::*;
(
  input  logic req,
  input  logic status,
  output logic lock
);

  assign lock = lock_needed(req, status);

endmodule

// File: rtl/lpx_enable_xing.sv
module lpx_enable_xing
  import lpx_pkg::*;
#(
  parameter int unsigned STAGES = LPX_SYNC_STAGES
) (
  input  logic sys_clk,
  input  logic sys_rst_n,
  input  logic slow_clk,
  input  logic slow_rst_n,
  input  logic enable_req,
  output logic slow_enable,
  output logic enable_status,
  output logic cfg_lock
);

  // Launch flop: the value that crosses must come straight from a register.
  logic launch_q;
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) launch_q <= 1'b0;
    else            launch_q <= enable_req;
  end

  // Forward crossing into the slow domain.
  logic fwd_q;
  lpx_sync #(.STAGES(STAGES)) u_fwd (
    .clk   (slow_clk),
    .rst_n (slow_rst_n),
    .d     (launch_q),
    .q     (fwd_q)
  );
  assign slow_enable = fwd_q;

  // Return crossing into the system domain.
  logic back_q;
  lpx_sync #(.STAGES(STAGES)) u_back (
    .clk   (sys_clk),
    .rst_n (sys_rst_n),
    .d     (fwd_q),
    .q     (back_q)
  );
  assign enable_status = back_q;

  // Lock for the slow generator's configuration fields.
  logic lock_w;
  lpx_lock u_lock (
    .req    (enable_req),
    .status (back_q),
    .lock   (lock_w)
  );
  assign cfg_lock = lock_w;

  // Assertions
  p_lock_on_status_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    enable_status |-> cfg_lock);

  p_lock_on_request_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    enable_req |-> cfg_lock);

  always @(posedge sys_clk) begin
    if (!sys_rst_n) begin
      p_sys_reset_clears_r7: assert (!enable_status && !launch_q);
    end
  end

  always @(posedge slow_clk) begin
    if (!slow_rst_n) begin
      p_slow_reset_clears_r8: assert (!slow_enable);
    end
  end

endmodule

// File: tb/test_lpx_enable_xing.sv
module test_lpx_enable_xing;

  localparam int STG = 2;
  localparam int TSYS = 8;

  logic sys_clk = 1'b0;
  logic slow_clk = 1'b0;
  logic sys_rst_n = 1'b0;
  logic slow_rst_n = 1'b0;
  logic enable_req = 1'b0;
  logic slow_enable, enable_status, cfg_lock;
  int slow_half = 122;
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 sys_clk = ~sys_clk;
  always #(slow_half) slow_clk = ~slow_clk;

  lpx_enable_xing i_lpx_enable_xing (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .slow_clk(slow_clk),
    .slow_rst_n(slow_rst_n), .enable_req(enable_req),
    .slow_enable(slow_enable), .enable_status(enable_status), .cfg_lock(cfg_lock)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lo_bound();
    return ((STG - 1) * 2 * slow_half) / TSYS;
  endfunction

  function automatic int hi_bound();
    return (STG * 2 * slow_half) / TSYS + STG + 4;
  endfunction

  // Counts system cycles until enable_status equals the target value.
  task automatic wait_status(input logic target, output int n);
    n = 0;
    while (enable_status !== target && n < 400) begin
      @(negedge sys_clk);
      n++;
    end
  endtask

  task automatic t_reset_state();
    check(enable_status === 1'b0, "R7 status in reset", enable_status, 0);
    check(cfg_lock === 1'b0, "R7 lock in reset", cfg_lock, 0);
    check(slow_enable === 1'b0, "R8 slow enable in reset", slow_enable, 0);
  endtask

  task automatic t_enable(input string lbl);
    int n;
    int m;
    @(negedge sys_clk);
    enable_req = 1'b1;
    #1;
    check(cfg_lock === 1'b1, {"R6 lock on request ", lbl}, cfg_lock, 1);
    m = 0;
    while (slow_enable !== 1'b1 && m < 400) begin
      @(negedge sys_clk);
      m++;
    end
    check(m >= lo_bound(), {"R1 slow enable not early ", lbl}, m, lo_bound());
    n = m;
    while (enable_status !== 1'b1 && n < 400) begin
      @(negedge sys_clk);
      n++;
    end
    check(n >= lo_bound(), {"R4 in-flight window ", lbl}, n, lo_bound());
    check(n <= hi_bound(), {"R3 enable latency ", lbl}, n, hi_bound());
    check(slow_enable === 1'b1, {"R2 status after slow side ", lbl}, slow_enable, 1);
  endtask

  task automatic t_disable(input string lbl);
    int n;
    @(negedge sys_clk);
    enable_req = 1'b0;
    #1;
    check(cfg_lock === 1'b1, {"R6 lock held by status ", lbl}, cfg_lock, 1);
    wait_status(1'b0, n);
    check(n >= lo_bound(), {"R5 status hold ", lbl}, n, lo_bound());
    check(n <= hi_bound(), {"R5 disable latency ", lbl}, n, hi_bound());
    check(slow_enable === 1'b0, {"R5 slow side off first ", lbl}, slow_enable, 0);
    check(cfg_lock === 1'b0, {"R6 unlock ", lbl}, cfg_lock, 0);
  endtask

  task automatic t_sys_reset();
    int n;
    @(negedge sys_clk);
    sys_rst_n = 1'b0;
    enable_req = 1'b0;
    #1;
    check(enable_status === 1'b0, "R7 status cleared", enable_status, 1'b0);
    check(cfg_lock === 1'b0, "R7 lock cleared", cfg_lock, 0);
    n = 0;
    while (slow_enable !== 1'b0 && n < 400) begin
      @(negedge sys_clk);
      n++;
    end
    check(n <= (STG * 2 * slow_half) / TSYS + 2, "R7 slow side drops", n,
          (STG * 2 * slow_half) / TSYS + 2);
    repeat (3) @(negedge sys_clk);
    sys_rst_n = 1'b1;
  endtask

  task automatic t_slow_reset();
    int n;
    @(negedge sys_clk);
    slow_rst_n = 1'b0;
    #1;
    check(slow_enable === 1'b0, "R8 slow enable forced", slow_enable, 0);
    wait_status(1'b0, n);
    check(n <= STG + 1, "R8 status falls", n, STG + 1);
    check(cfg_lock === 1'b1, "R6 lock held by request", cfg_lock, 1);
    repeat (5) @(negedge sys_clk);
    slow_rst_n = 1'b1;
    wait_status(1'b1, n);
    check(n <= hi_bound(), "R8 round trip resumes", n, hi_bound());
  endtask

  initial begin
    forever begin
      @(posedge sys_clk);
      cyc++;
      if (cyc > 150000) begin
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge sys_clk);
    t_reset_state();
    sys_rst_n = 1'b1;
    slow_rst_n = 1'b1;
    repeat (4) @(negedge sys_clk);

    slow_half = 122;
    t_enable("ratio 30.5");
    t_disable("ratio 30.5");

    slow_half = 188;
    repeat (100) @(negedge sys_clk);
    t_enable("ratio 47");
    t_disable("ratio 47");

    t_enable("before sys reset");
    t_sys_reset();
    repeat (4) @(negedge sys_clk);

    t_enable("before slow reset");
    t_slow_reset();
    t_disable("after slow reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule